// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit core and a data memory that is one word wide. On the request side it takes an operation code, an access size, a signedness flag, a byte address, the register value to be stored and a 16-bit immediate. In the same cycle it drives the word address, a per-lane byte-enable mask, a read strobe and the write data, with the data copied into every lane. The byte enables alone then pick which lanes the memory updates. A request whose address does not suit its size is flagged and never reaches the memory.

Load context (offset, size, signedness) is registered with the request. The memory word comes back in the next cycle, and the unit picks the addressed byte, halfword or word out of it and extends it to 32 bits. The immediate-to-upper-half operation uses the same one-cycle result slot and does not touch memory.

Top module: `lsu_align_top`

## Requirements
- R1: `memAddr` equals `reqAddr` with bits 1:0 forced to zero, for every request.
- R2: For an aligned store (op 2), `memByteEn` bit k is set for each byte lane written. Lane k covers data bits 8k+7:8k, and lane 0 is the lowest address. A byte store (size 0) sets only bit `reqAddr[1:0]`. A halfword store (size 1) sets 4'b0011 or 4'b1100. A word store (size 2) sets 4'b1111. Loads, immediates and idle cycles drive 4'b0000.
- R3: For a store, `memWrData` holds the low byte of `storeData` copied four times (byte), the low halfword copied twice (halfword), or `storeData` unchanged (word).
- R4: A load or store is misaligned when any of these holds: a halfword has an odd address, a word has a nonzero `reqAddr[1:0]`, or the size code is 3. Such a request raises `misAlign` in the same cycle, drives `memByteEn` to zero and `memRead` low, and produces no result.
- R5: An aligned byte load (op 1, size 0) asserts `memRead`. In the next cycle it presents the selected byte of `memRdData`, sign-extended when `reqSigned` is 1 and zero-extended when it is 0.
- R6: An aligned halfword load selects bits 15:0 (address bit 1 clear) or 31:16 (address bit 1 set) of `memRdData` and extends them by the same signedness rule as R5.
- R7: An aligned word load returns `memRdData` unchanged in the next cycle.
- R8: The immediate operation (op 3) returns `{immVal, 16'h0000}` in the next cycle. It asserts neither `memRead` nor any byte enable.
- R9: `resultValid` is high exactly in the cycle after an accepted aligned load or an immediate operation. It is low after stores, misaligned requests, op 0 and cycles with `reqValid` low. `loadResult` is zero whenever `resultValid` is low.
- R10: While `rstN` is low and after its release, `resultValid` is low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 none, 1 load, 2 store, 3 immediate-to-upper |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqSigned | input | 1 | Sign-extend a byte or halfword load |
| reqAddr | input | 32 | Byte address of the access |
| storeData | input | 32 | Register value for a store |
| immVal | input | 16 | Constant for the upper-half operation |
| memRdData | input | 32 | Word returned by memory one cycle after `memRead` |
| memAddr | output | 32 | Word-aligned memory address |
| memByteEn | output | 4 | Per-lane write enables |
| memWrData | output | 32 | Lane-replicated write data |
| memRead | output | 1 | Read strobe for an aligned load |
| misAlign | output | 1 | Request rejected for bad alignment or size |
| loadResult | output | 32 | Extended load or immediate result |
| resultValid | output | 1 | `loadResult` is valid |

## Verification
Some rules hold on every cycle. A misaligned request never drives a lane or a read. A store enables one, two or four lanes and never reads. `resultValid` only follows an accepted load or immediate. An unsigned byte result keeps its upper 24 bits clear. An immediate result keeps its low half clear. The exact lane chosen for each offset, the copy pattern in the write data, and the sign-fill value for each size and offset are only shown by the bench's vectors. The same holds for the rejection of each misaligned case and the one-cycle result pulse after back-to-back requests.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 32;
  parameter int IMM_W  = DATA_W / 2;
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_UPPER = 2'd3
  } accOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [LANES-1:0] laneMask;
    logic             doWrite;
    accSize_e         curSize;
    logic             capImm;
    accSize_e         selSize;
    logic [OFF_W-1:0] selOff;
    logic             selSigned;
    logic             selUpper;
    logic             resVal;
  } strobes_t;
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqSize,
  input  logic             reqSigned,
  input  logic [OFF_W-1:0] reqOff,
  output strobes_t         stb,
  output logic             memRead,
  output logic             misAlign
);
  logic isLoad, isStore, isUpper, aligned;
  logic [LANES-1:0] rawMask;
  accSize_e szIn;

  assign szIn = accSize_e'(reqSize);

  always_comb begin
    isLoad  = reqValid && (accOp_e'(reqOp) == OP_LOAD);
    isStore = reqValid && (accOp_e'(reqOp) == OP_STORE);
    isUpper = reqValid && (accOp_e'(reqOp) == OP_UPPER);
    unique case (szIn)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = (reqOff[0] == 1'b0);
      SZ_WORD: aligned = (reqOff == '0);
      default: aligned = 1'b0;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (szIn)
        SZ_BYTE: rawMask[k] = (reqOff == OFF_W'(k));
        SZ_HALF: rawMask[k] = (reqOff[OFF_W-1:1] == (OFF_W-1)'(k >> 1));
        SZ_WORD: rawMask[k] = 1'b1;
        default: rawMask[k] = 1'b0;
      endcase
    end
  end

  assign misAlign       = (isLoad || isStore) && !aligned;
  assign memRead        = isLoad && aligned;
  assign stb.doWrite    = isStore && aligned;
  assign stb.laneMask   = stb.doWrite ? rawMask : '0;
  assign stb.curSize    = szIn;
  assign stb.capImm     = isUpper;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stb.selSize   <= SZ_BYTE;
      stb.selOff    <= '0;
      stb.selSigned <= 1'b0;
      stb.selUpper  <= 1'b0;
      stb.resVal    <= 1'b0;
    end else begin
      stb.selSize   <= szIn;
      stb.selOff    <= reqOff;
      stb.selSigned <= reqSigned;
      stb.selUpper  <= isUpper;
      stb.resVal    <= (isLoad && aligned) || isUpper;
    end
  end

  // R4
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    misAlign |-> (stb.laneMask == '0 && !memRead));

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |-> ($countones(stb.laneMask) == 1 || $countones(stb.laneMask) == 2
                     || $countones(stb.laneMask) == LANES));

  // R9
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.resVal |-> $past(reqValid && (accOp_e'(reqOp) == OP_LOAD || accOp_e'(reqOp) == OP_UPPER)));

  // R9
  read_write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> !stb.doWrite);
endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] loadResult
);
  localparam int HALF_W = 16;
  logic [IMM_W-1:0]  immReg;
  logic [7:0]        pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic              fill;

  assign memAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar k = 0; k < LANES; k++) begin : g_rep
    always_comb begin
      unique case (stb.curSize)
        SZ_BYTE: memWrData[k*8 +: 8] = storeData[7:0];
        SZ_HALF: memWrData[k*8 +: 8] = storeData[(k % 2)*8 +: 8];
        default: memWrData[k*8 +: 8] = storeData[k*8 +: 8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           immReg <= '0;
    else if (stb.capImm) immReg <= immVal;
  end

  always_comb begin
    pickByte   = memRdData[{stb.selOff, 3'b000} +: 8];
    pickHalf   = memRdData[{stb.selOff[OFF_W-1:1], 4'b0000} +: HALF_W];
    fill       = 1'b0;
    loadResult = '0;
    if (stb.resVal) begin
      if (stb.selUpper) begin
        loadResult = {immReg, {(DATA_W-IMM_W){1'b0}}};
      end else begin
        unique case (stb.selSize)
          SZ_BYTE: begin
            fill       = stb.selSigned && pickByte[7];
            loadResult = {{(DATA_W-8){fill}}, pickByte};
          end
          SZ_HALF: begin
            fill       = stb.selSigned && pickHalf[HALF_W-1];
            loadResult = {{(DATA_W-HALF_W){fill}}, pickHalf};
          end
          default: loadResult = memRdData;
        endcase
      end
    end
  end

  // R5
  unsigned_byte_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resVal && !stb.selUpper && stb.selSize == SZ_BYTE && !stb.selSigned)
      |-> (loadResult[DATA_W-1:8] == '0));

  // R8
  upper_low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.resVal && stb.selUpper) |-> (loadResult[DATA_W-IMM_W-1:0] == '0));
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_align_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [1:0]  reqSize,
  input  logic        reqSigned,
  input  logic [31:0] reqAddr,
  input  logic [31:0] storeData,
  input  logic [15:0] immVal,
  input  logic [31:0] memRdData,
  output logic [31:0] memAddr,
  output logic [3:0]  memByteEn,
  output logic [31:0] memWrData,
  output logic        memRead,
  output logic        misAlign,
  output logic [31:0] loadResult,
  output logic        resultValid
);
  strobes_t stb;

  lsu_align_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqOff(reqAddr[OFF_W-1:0]),
    .stb(stb), .memRead(memRead), .misAlign(misAlign)
  );

  lsu_align_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .storeData(storeData), .immVal(immVal), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .loadResult(loadResult)
  );

  assign memByteEn   = stb.laneMask;
  assign resultValid = stb.resVal;
endmodule

// File: tb/lsu_align_top_tb_top.sv
module lsu_align_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0, reqSize = 2'd0;
  logic        reqSigned = 1'b0;
  logic [31:0] reqAddr = '0, storeData = 32'hA1B2C3D4, memRdData = 32'hF1807F02;
  logic [15:0] immVal = '0;
  logic [31:0] memAddr, memWrData, loadResult;
  logic [3:0]  memByteEn;
  logic        memRead, misAlign, resultValid;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  lsu_align_top dut_i (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  size;
    logic        sgn;
    logic [31:0] addr;
    logic [15:0] imm;
    logic [3:0]  be;
    logic [31:0] wr;
    logic        mis;
    logic        rd;
    logic        val;
    logic [31:0] res;
  } vec_t;

  localparam int VN = 18;
  // storeData = A1B2C3D4, memRdData = F1807F02 (lanes 02,7F,80,F1)
  localparam vec_t VECS [VN] = '{
    '{2'd2, 2'd0, 1'b0, 32'h1003, 16'h0, 4'b1000, 32'hD4D4D4D4, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd0, 1'b0, 32'h1000, 16'h0, 4'b0001, 32'hD4D4D4D4, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd1, 1'b0, 32'h2002, 16'h0, 4'b1100, 32'hC3D4C3D4, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd1, 1'b0, 32'h2000, 16'h0, 4'b0011, 32'hC3D4C3D4, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd2, 1'b0, 32'h3000, 16'h0, 4'b1111, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd1, 1'b0, 32'h2001, 16'h0, 4'b0000, 32'h0,       1'b1, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd2, 1'b0, 32'h3002, 16'h0, 4'b0000, 32'h0,       1'b1, 1'b0, 1'b0, 32'h0},
    '{2'd2, 2'd3, 1'b0, 32'h3000, 16'h0, 4'b0000, 32'h0,       1'b1, 1'b0, 1'b0, 32'h0},
    '{2'd1, 2'd0, 1'b1, 32'h4002, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'hFFFFFF80},
    '{2'd1, 2'd0, 1'b0, 32'h4002, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'h00000080},
    '{2'd1, 2'd0, 1'b1, 32'h4001, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'h0000007F},
    '{2'd1, 2'd0, 1'b1, 32'h4003, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'hFFFFFFF1},
    '{2'd1, 2'd1, 1'b1, 32'h4002, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'hFFFFF180},
    '{2'd1, 2'd1, 1'b0, 32'h4002, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'h0000F180},
    '{2'd1, 2'd1, 1'b1, 32'h4000, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'h00007F02},
    '{2'd1, 2'd2, 1'b1, 32'h4004, 16'h0, 4'b0000, 32'h0,       1'b0, 1'b1, 1'b1, 32'hF1807F02},
    '{2'd1, 2'd2, 1'b0, 32'h4005, 16'h0, 4'b0000, 32'h0,       1'b1, 1'b0, 1'b0, 32'h0},
    '{2'd3, 2'd0, 1'b0, 32'h5001, 16'hBEEF, 4'b0000, 32'h0,    1'b0, 1'b0, 1'b1, 32'hBEEF0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 resultValid in reset", {31'b0, resultValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 resultValid after reset", {31'b0, resultValid}, 32'h0);
    chk("R9 idle result zero", loadResult, 32'h0);

    for (int i = 0; i < VN; i++) begin
      reqValid  = 1'b1;
      reqOp     = VECS[i].op;
      reqSize   = VECS[i].size;
      reqSigned = VECS[i].sgn;
      reqAddr   = VECS[i].addr;
      immVal    = VECS[i].imm;
      #2;
      chk("R1 memAddr", memAddr, VECS[i].addr & 32'hFFFFFFFC);
      chk("R2 memByteEn", {28'b0, memByteEn}, {28'b0, VECS[i].be});
      chk("R4 misAlign", {31'b0, misAlign}, {31'b0, VECS[i].mis});
      chk("R5 memRead", {31'b0, memRead}, {31'b0, VECS[i].rd});
      if (VECS[i].op == 2'd2 && !VECS[i].mis) chk("R3 memWrData", memWrData, VECS[i].wr);
      @(negedge clk);
      reqValid = 1'b0;
      #2;
      chk("R9 resultValid", {31'b0, resultValid}, {31'b0, VECS[i].val});
      chk("R6 R7 R8 loadResult", loadResult, VECS[i].res);
      @(negedge clk);
    end

    // R9: idle cycle drives nothing
    #2;
    chk("R2 idle byteEn", {28'b0, memByteEn}, 32'h0);
    chk("R5 idle memRead", {31'b0, memRead}, 32'h0);
    chk("R9 idle valid", {31'b0, resultValid}, 32'h0);

    // R8 then R7 back to back; immediate must not read or enable lanes
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd3; immVal = 16'h1234; reqAddr = 32'h0;
    #2;
    chk("R8 no read on upper", {31'b0, memRead}, 32'h0);
    chk("R8 no lanes on upper", {28'b0, memByteEn}, 32'h0);
    @(negedge clk);
    reqOp = 2'd1; reqSize = 2'd2; reqAddr = 32'h8; memRdData = 32'h00C0FFEE;
    #2;
    chk("R8 upper result", loadResult, 32'h12340000);
    @(negedge clk);
    reqValid = 1'b0;
    #2;
    chk("R7 word after upper", loadResult, 32'h00C0FFEE);
    @(negedge clk);
    #2;
    chk("R9 pulse ends", {31'b0, resultValid}, 32'h0);

    // R9: op 0 with reqValid high yields nothing
    reqValid = 1'b1; reqOp = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    #2;
    chk("R9 op none", {31'b0, resultValid}, 32'h0);

    // R10: reset mid-operation clears pending result
    reqValid = 1'b1; reqOp = 2'd1; reqSize = 2'd0; reqAddr = 32'h1;
    rstN = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    #2;
    chk("R10 reset kills result", {31'b0, resultValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule